// File: doc/BRIEF.md
# Two-Bank Row Timing Guard

This block sits in front of a two-bank DRAM command path and decides, within the cycle a command is offered, whether that command may go out. Each offered command names one of four operations (open a row, column read, column write, close the row) and one of two banks. The guard keeps a small state machine and a cycle counter for each bank, plus one shared counter for spacing row opens across banks. From these it raises a single allow flag for the offered command and reports which banks hold an open row.

Every interval is a parameter counted in clock cycles; each is obtained by dividing the analog minimum time by the clock period and rounding up to the next whole cycle. The guard also reports, per bank, when a row has been held open past its longest permitted time, so that a controller can close it. A command that is refused leaves every counter and state untouched; the caller simply offers it again later.

Top module: `bank_act_guard`

## Requirements
- R1: After reset both banks are closed (`bank_open` = 2'b00), `ras_overrun` = 2'b00, and `cmd_allow` is low while `cmd_valid` is low.
- R2: An open-row command (`cmd_op` = 2'b00) to a closed, recovered bank is allowed, and from the next cycle that bank's bit of `bank_open` is high.
- R3: An open-row command to a bank whose row is already open is refused.
- R4: A column read (`cmd_op` = 2'b01) or column write (`cmd_op` = 2'b10) to a bank that is not open is refused.
- R5: A read or write to an open bank is allowed only when at least `T_RCD` cycles have passed since that bank's open command was accepted: refused at `T_RCD`-1 cycles, allowed at `T_RCD`.
- R6: An open-row command to one bank is allowed only when at least `T_RRD` cycles have passed since the last accepted open-row command to the other bank.
- R7: A close command (`cmd_op` = 2'b11) is refused on a bank that is not open, and on an open bank until `T_RAS_MIN` cycles have passed since its open; once accepted, the bank's `bank_open` bit is low from the next cycle.
- R8: After an accepted close, an open-row command to that bank is refused until `T_RP` cycles have passed since the close, and allowed at `T_RP`.
- R9: A bank's `ras_overrun` bit is high while its row has been open for more than `T_RAS_MAX` cycles (low at `T_RAS_MAX`, high at `T_RAS_MAX`+1) and is low from the cycle after the row is closed.
- R10: A refused command restarts no interval: the windows of R6 and R8 keep counting from the last accepted command.
- R11: With `cmd_valid` low, `cmd_allow` is low and no bank state changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_op | input | 2 | 00 open row, 01 read, 10 write, 11 close row |
| cmd_bank | input | 1 | Target bank |
| cmd_allow | output | 1 | The offered command may issue this cycle (combinational) |
| bank_open | output | 2 | Per-bank open-row status |
| ras_overrun | output | 2 | Per-bank flag: row held open past its maximum time |

## Verification
`cmd_allow` is combinational, so each check reads it in the same cycle the command is offered, after inputs settle and before the clock edge that would accept it. `bank_open` and the interval counters change on that edge, so status is read one cycle later, and an interval of N cycles is probed by offering the command at exactly N-1 and N cycles after the accepting edge. `ras_overrun` follows the row's age directly and is sampled in the cycles T_RAS_MAX and T_RAS_MAX+1 after the open, then one cycle after the close.

// File: rtl/bag_pkg.sv
package bag_pkg;
  localparam int NUM_BANKS = 2;
  localparam int BANK_W    = 1;

  typedef enum logic [1:0] {
    OP_OPEN  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_CLOSE = 2'b11
  } cmd_op_e;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'b00,
    BK_ACTIVE = 2'b01,
    BK_PRECH  = 2'b10
  } bank_state_e;
endpackage

// File: rtl/bag_bank_fsm.sv
module bag_bank_fsm
  import bag_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RAS_MIN = 6,
  parameter int T_RAS_MAX = 20,
  parameter int T_RP      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic do_open,
  input  logic do_close,
  output logic open_ok,
  output logic col_ok,
  output logic close_ok,
  output logic is_open,
  output logic overrun
);
  localparam int CNT_MAX = T_RAS_MAX + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  bank_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             state_en, cnt_en;
  logic             cnt_sat;

  assign cnt_sat  = (cnt_q == CNT_W'(CNT_MAX));
  assign is_open  = (state_q == BK_ACTIVE);
  assign open_ok  = (state_q == BK_IDLE) ||
                    ((state_q == BK_PRECH) && (cnt_q >= CNT_W'(T_RP)));
  assign col_ok   = is_open && (cnt_q >= CNT_W'(T_RCD));
  assign close_ok = is_open && (cnt_q >= CNT_W'(T_RAS_MIN));
  assign overrun  = is_open && (cnt_q > CNT_W'(T_RAS_MAX));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      BK_IDLE: begin
        if (do_open) begin
          state_d = BK_ACTIVE;
          cnt_d   = CNT_W'(1);
        end
      end
      BK_ACTIVE: begin
        if (do_close) begin
          state_d = BK_PRECH;
          cnt_d   = CNT_W'(1);
        end else if (!cnt_sat) begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      BK_PRECH: begin
        if (do_open) begin
          state_d = BK_ACTIVE;
          cnt_d   = CNT_W'(1);
        end else if (cnt_q >= CNT_W'(T_RP)) begin
          state_d = BK_IDLE;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        state_d = BK_IDLE;
      end
    endcase
  end

  assign state_en = (state_d != state_q);
  assign cnt_en   = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BK_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/bag_rrd_tracker.sv
module bag_rrd_tracker
  import bag_pkg::*;
#(
  parameter int T_RRD = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 do_open,
  input  logic [BANK_W-1:0]    open_bank,
  output logic [NUM_BANKS-1:0] blocked
);
  localparam int CNT_W = $clog2(T_RRD + 1) + 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BANK_W-1:0] last_q, last_d;
  logic              cnt_en, last_en;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_blk
    assign blocked[b] = (last_q != BANK_W'(b)) && (cnt_q < CNT_W'(T_RRD));
  end

  always_comb begin
    cnt_d  = cnt_q;
    last_d = last_q;
    if (do_open) begin
      cnt_d  = CNT_W'(1);
      last_d = open_bank;
    end else if (cnt_q < CNT_W'(T_RRD)) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  assign cnt_en  = (cnt_d != cnt_q);
  assign last_en = do_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(T_RRD);
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
    end else if (last_en) begin
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/bank_act_guard.sv
module bank_act_guard
  import bag_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RAS_MIN = 6,
  parameter int T_RAS_MAX = 20,
  parameter int T_RP      = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_bank,
  output logic       cmd_allow,
  output logic [1:0] bank_open,
  output logic [1:0] ras_overrun
);
  logic [NUM_BANKS-1:0] open_ok, col_ok, close_ok, rrd_blocked;
  logic [NUM_BANKS-1:0] do_open, do_close;
  logic                 accept_open;
  cmd_op_e              op;

  assign op = cmd_op_e'(cmd_op);

  always_comb begin
    cmd_allow = 1'b0;
    if (cmd_valid) begin
      unique case (op)
        OP_OPEN:           cmd_allow = open_ok[cmd_bank] && !rrd_blocked[cmd_bank];
        OP_READ, OP_WRITE: cmd_allow = col_ok[cmd_bank];
        OP_CLOSE:          cmd_allow = close_ok[cmd_bank];
        default:           cmd_allow = 1'b0;
      endcase
    end
  end

  assign accept_open = cmd_allow && (op == OP_OPEN);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign do_open[b]  = accept_open && (cmd_bank == BANK_W'(b));
    assign do_close[b] = cmd_allow && (op == OP_CLOSE) && (cmd_bank == BANK_W'(b));

    bag_bank_fsm #(
      .T_RCD     (T_RCD),
      .T_RAS_MIN (T_RAS_MIN),
      .T_RAS_MAX (T_RAS_MAX),
      .T_RP      (T_RP)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_open  (do_open[b]),
      .do_close (do_close[b]),
      .open_ok  (open_ok[b]),
      .col_ok   (col_ok[b]),
      .close_ok (close_ok[b]),
      .is_open  (bank_open[b]),
      .overrun  (ras_overrun[b])
    );
  end

  bag_rrd_tracker #(
    .T_RRD (T_RRD)
  ) u_rrd (
    .clk       (clk),
    .rst_n     (rst_n),
    .do_open   (accept_open),
    .open_bank (cmd_bank),
    .blocked   (rrd_blocked)
  );
endmodule

// File: rtl/bank_act_guard_chk.sv
module bank_act_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       cmd_bank,
  input logic       cmd_allow,
  input logic [1:0] bank_open,
  input logic [1:0] ras_overrun
);
  AST_ALLOW_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> !cmd_allow); // R11

  AST_OPEN_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_allow && cmd_op == 2'b00) |=> bank_open[$past(cmd_bank)]); // R2

  AST_NO_OPEN_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b00 && bank_open[cmd_bank]) |-> !cmd_allow); // R3

  AST_NO_COL_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 2'b01 || cmd_op == 2'b10) && !bank_open[cmd_bank])
      |-> !cmd_allow); // R4

  AST_CLOSE_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_allow && cmd_op == 2'b11) |=> !bank_open[$past(cmd_bank)]); // R7

  AST_OVERRUN_B0_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ras_overrun[0] |-> bank_open[0]); // R9

  AST_OVERRUN_B1_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ras_overrun[1] |-> bank_open[1]); // R9

  AST_IDLE_HOLDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && bank_open == 2'b00) |=> (bank_open == 2'b00)); // R11
endmodule

bind bank_act_guard bank_act_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .cmd_bank    (cmd_bank),
  .cmd_allow   (cmd_allow),
  .bank_open   (bank_open),
  .ras_overrun (ras_overrun)
);

// File: tb/bank_act_guard_tb.sv
`timescale 1ns/1ps
module bank_act_guard_tb;
  localparam int T_RCD     = 3;
  localparam int T_RRD     = 2;
  localparam int T_RAS_MIN = 6;
  localparam int T_RAS_MAX = 20;
  localparam int T_RP      = 3;

  localparam logic [1:0] OPEN  = 2'b00;
  localparam logic [1:0] RD    = 2'b01;
  localparam logic [1:0] WR    = 2'b10;
  localparam logic [1:0] CLOSE = 2'b11;

  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [1:0] cmd_op;
  logic       cmd_bank;
  logic       cmd_allow;
  logic [1:0] bank_open;
  logic [1:0] ras_overrun;

  int checks;
  int errors;
  bit done;

  bank_act_guard #(
    .T_RCD(T_RCD), .T_RRD(T_RRD), .T_RAS_MIN(T_RAS_MIN),
    .T_RAS_MAX(T_RAS_MAX), .T_RP(T_RP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_allow(cmd_allow), .bank_open(bank_open),
    .ras_overrun(ras_overrun)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Offer one command for one cycle; returns cmd_allow seen before the edge.
  task automatic step(input bit v, input logic [1:0] op, input bit bk, output bit al);
    @(negedge clk);
    cmd_valid = v;
    cmd_op    = op;
    cmd_bank  = bk;
    #1;
    al = cmd_allow;
  endtask

  task automatic quiet(input int n);
    bit al;
    for (int i = 0; i < n; i++) step(1'b0, OPEN, 1'b0, al);
  endtask

  task automatic do_reset();
    cmd_valid = 1'b0;
    cmd_op    = OPEN;
    cmd_bank  = 1'b0;
    rst_n     = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    bit al;
    do_reset();
    step(1'b0, OPEN, 1'b0, al);
    check("R1 bank_open", int'(bank_open), 0);
    check("R1 ras_overrun", int'(ras_overrun), 0);
    check("R1 allow idle", int'(al), 0);
  endtask

  task automatic t_open_rcd();
    bit al;
    do_reset();
    step(1'b1, OPEN, 1'b0, al);                  // step 0
    check("R2 open idle bank", int'(al), 1);
    step(1'b1, RD, 1'b0, al);                    // step 1
    check("R2 bank_open after open", int'(bank_open), 1);
    check("R5 read at 1", int'(al), 0);
    step(1'b1, WR, 1'b0, al);                    // step 2
    check("R5 write at T_RCD-1", int'(al), 0);
    step(1'b1, RD, 1'b0, al);                    // step 3
    check("R5 read at T_RCD", int'(al), 1);
    step(1'b1, WR, 1'b0, al);
    check("R5 write after T_RCD", int'(al), 1);
    step(1'b1, RD, 1'b1, al);
    check("R4 read closed bank", int'(al), 0);
    step(1'b1, WR, 1'b1, al);
    check("R4 write closed bank", int'(al), 0);
    step(1'b1, OPEN, 1'b0, al);
    check("R3 open on open bank", int'(al), 0);
    step(1'b0, OPEN, 1'b0, al);
    check("R3 status unchanged", int'(bank_open), 1);
  endtask

  task automatic t_rrd();
    bit al;
    do_reset();
    step(1'b1, OPEN, 1'b0, al);                  // step 0
    check("R6 first open", int'(al), 1);
    step(1'b1, OPEN, 1'b1, al);                  // step 1
    check("R6 other bank at T_RRD-1", int'(al), 0);
    step(1'b1, OPEN, 1'b1, al);                  // step 2
    check("R10 refused open no restart", int'(al), 1);
    step(1'b0, OPEN, 1'b0, al);
    check("R6 both open", int'(bank_open), 3);
  endtask

  task automatic t_ras_rp();
    bit al;
    do_reset();
    step(1'b1, OPEN, 1'b0, al);                  // step 0
    step(1'b1, CLOSE, 1'b1, al);                 // step 1
    check("R7 close on closed bank", int'(al), 0);
    quiet(3);                                    // steps 2..4
    step(1'b1, CLOSE, 1'b0, al);                 // step 5
    check("R7 close at T_RAS_MIN-1", int'(al), 0);
    step(1'b1, CLOSE, 1'b0, al);                 // step 6
    check("R7 close at T_RAS_MIN", int'(al), 1);
    step(1'b1, OPEN, 1'b0, al);                  // step 7, 1 after close
    check("R7 bank_open cleared", int'(bank_open), 0);
    check("R8 open at 1 after close", int'(al), 0);
    step(1'b1, OPEN, 1'b0, al);                  // step 8
    check("R8 open at T_RP-1", int'(al), 0);
    step(1'b1, OPEN, 1'b0, al);                  // step 9
    check("R10 R8 open at T_RP", int'(al), 1);
  endtask

  task automatic t_overrun();
    bit al;
    do_reset();
    step(1'b1, OPEN, 1'b1, al);                  // step 0
    quiet(T_RAS_MAX - 1);                        // steps 1..T_RAS_MAX-1
    step(1'b0, OPEN, 1'b0, al);                  // step T_RAS_MAX
    check("R9 no overrun at T_RAS_MAX", int'(ras_overrun), 0);
    step(1'b1, CLOSE, 1'b1, al);                 // step T_RAS_MAX+1
    check("R9 overrun at T_RAS_MAX+1", int'(ras_overrun), 2);
    check("R9 close allowed", int'(al), 1);
    step(1'b0, OPEN, 1'b0, al);
    check("R9 overrun cleared", int'(ras_overrun), 0);
  endtask

  task automatic t_valid_low();
    bit al;
    do_reset();
    step(1'b0, OPEN, 1'b0, al);
    check("R11 allow with valid low", int'(al), 0);
    step(1'b0, OPEN, 1'b1, al);
    check("R11 no state change", int'(bank_open), 0);
    step(1'b1, OPEN, 1'b1, al);
    check("R11 open still allowed", int'(al), 1);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    t_reset();
    t_open_rcd();
    t_rrd();
    t_ras_rp();
    t_overrun();
    t_valid_low();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule